// File: doc/BRIEF.md
# Bit-Serial Register File

This block is the register store for a core whose datapath is one bit wide. It holds thirty-six 32-bit words: thirty-two general-purpose registers at addresses 0 to 31 and four control/status registers at addresses 32 to 35, reached through a 6-bit address. Toward the core it offers two serial read ports and two serial write ports. Each port moves one bit per cycle, least significant bit first, for 32 cycles.

Each direction runs its own short handshake. The core pulses a request for one cycle. On the following cycle it drives the two addresses, and for writes also the two write enables. The register file then pulses a ready strobe. The serial data starts on the cycle after that strobe. The delay from request to ready is set by a separate parameter for reads (`RD_LAT`) and for writes (`WR_LAT`). Both must be at least 2.

A read copies both addressed words into per-port shift registers when it samples the addresses, and then shifts them out. A write gathers the incoming bits in per-port shift registers. It stores the words into the array on the edge that takes the final bit.

Top module: `rfb_top`

## Requirements
- R1: After reset, `rd_rdy` and `wr_rdy` are low and every one of the 36 registers reads as zero.
- R2: If `rd_req` is high in cycle 0 while no read is active, the read addresses are sampled in cycle 1, and `rd_rdy` is high for exactly one cycle, cycle `RD_LAT`.
- R3: During a read, bit k of each addressed register is on `rd_bit_a` / `rd_bit_b` in cycle `RD_LAT`+1+k, for k = 0 to 31 (LSB first).
- R4: If `wr_req` is high in cycle 0 while no write is active, the write addresses and write enables are sampled in cycle 1, and `wr_rdy` is high for exactly one cycle, cycle `WR_LAT`.
- R5: Bit k of the write data is sampled from `wr_bit_a` / `wr_bit_b` in cycle `WR_LAT`+1+k. The assembled word is stored at the end of cycle `WR_LAT`+32 and is returned by any read whose addresses are sampled afterwards.
- R6: A write port whose enable was low in cycle 1 leaves its addressed register unchanged.
- R7: Address 0 always reads as zero, and writes to it are dropped.
- R8: Addresses 32 to 35 hold ordinary 32-bit storage. Addresses 36 to 63 read as zero, and writes to them are dropped.
- R9: When both write ports are enabled for the same address, the word from port B is the one stored.
- R10: A request that arrives while a transfer in the same direction is active is ignored and produces no further ready pulse.
- R11: Reads and writes run independently and may overlap. A read returns the contents the array held when its addresses were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | One-cycle read request strobe |
| rd_addr_a | input | 6 | Read address, port A (valid the cycle after `rd_req`) |
| rd_addr_b | input | 6 | Read address, port B (valid the cycle after `rd_req`) |
| rd_rdy | output | 1 | Read ready strobe, one cycle before bit 0 |
| rd_bit_a | output | 1 | Serial read data, port A |
| rd_bit_b | output | 1 | Serial read data, port B |
| wr_req | input | 1 | One-cycle write request strobe |
| wr_addr_a | input | 6 | Write address, port A (valid the cycle after `wr_req`) |
| wr_addr_b | input | 6 | Write address, port B (valid the cycle after `wr_req`) |
| wr_en_a | input | 1 | Write enable, port A (sampled with the address) |
| wr_en_b | input | 1 | Write enable, port B (sampled with the address) |
| wr_rdy | output | 1 | Write ready strobe, one cycle before bit 0 is taken |
| wr_bit_a | input | 1 | Serial write data, port A |
| wr_bit_b | input | 1 | Serial write data, port B |

## Verification
Every transfer is measured from the cycle of its request, which counts as cycle 0. The addresses are driven in cycle 1. Ready is due in cycle `RD_LAT` or `WR_LAT`. Data bit k is due in ready+1+k, and a written word is visible to a read only when that read's addresses are sampled after cycle `WR_LAT`+32. The bench moves inputs 1 ns after a rising edge and samples outputs at the falling edge of the very cycle in which each result is due. It also confirms that ready is low in the cycles on either side of its pulse. The bound checker keeps its own count of cycles since each accepted request. From that count it requires ready exactly at the latency, and zero data on a port whose address was 0 or above 35.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    // number of serial ports in each direction
    localparam int NPORT = 2;

    // transfer sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_WAIT,
        SQ_STREAM
    } seq_state_e;

endpackage

// File: rtl/rfb_seq.sv
// Request -> address -> ready -> 32-bit stream sequencer for one direction.
module rfb_seq
    import rfb_pkg::*;
#(
    parameter int LAT  = 2,
    parameter int XLEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic capture,
    output logic rdy,
    output logic stream,
    output logic last_bit
);
    localparam int CMAX = (LAT > XLEN) ? LAT : XLEN;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (req) s_d.st = SQ_ADDR;
            end
            SQ_ADDR: begin
                s_d.st  = SQ_WAIT;
                s_d.cnt = CW'(2);
            end
            SQ_WAIT: begin
                if (s_q.cnt >= CW'(LAT)) begin
                    s_d.st  = SQ_STREAM;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            SQ_STREAM: begin
                if (s_q.cnt == CW'(XLEN - 1)) begin
                    s_d.st  = SQ_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            default: s_d = '{st: SQ_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign capture  = (s_q.st == SQ_ADDR);
    assign rdy      = (s_q.st == SQ_WAIT) && (s_q.cnt >= CW'(LAT));
    assign stream   = (s_q.st == SQ_STREAM);
    assign last_bit = stream && (s_q.cnt == CW'(XLEN - 1));

endmodule

// File: rtl/rfb_rdpath.sv
// Per-port read shifter: parallel load at capture, LSB-first serial out.
module rfb_rdpath #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            stream,
    input  logic [XLEN-1:0] word,
    output logic            bit_o
);
    logic [XLEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (capture)     sh_d = word;
        else if (stream) sh_d = {1'b0, sh_q[XLEN-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign bit_o = sh_q[0];

endmodule

// File: rtl/rfb_wrpath.sv
// Per-port write collector: latches address/enable, assembles serial bits.
module rfb_wrpath #(
    parameter int XLEN = 32,
    parameter int AW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            stream,
    input  logic [AW-1:0]   addr_i,
    input  logic            en_i,
    input  logic            bit_i,
    output logic [AW-1:0]   addr_o,
    output logic            en_o,
    output logic [XLEN-1:0] word_o
);
    typedef struct packed {
        logic [AW-1:0]   addr;
        logic            en;
        logic [XLEN-1:0] sh;
    } wp_t;

    wp_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (capture) begin
            w_d.addr = addr_i;
            w_d.en   = en_i;
        end
        if (stream) w_d.sh = {bit_i, w_q.sh[XLEN-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign addr_o = w_q.addr;
    assign en_o   = w_q.en;
    // word including the bit arriving this cycle; complete on the last bit
    assign word_o = {bit_i, w_q.sh[XLEN-1:1]};

endmodule

// File: rtl/rfb_array.sv
// Storage array: combinational read mux, commit of both write ports.
module rfb_array
    import rfb_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 36,
    parameter int AW    = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_addr [NPORT],
    output logic [XLEN-1:0] rd_word [NPORT],
    input  logic            commit,
    input  logic [AW-1:0]   wr_addr [NPORT],
    input  logic            wr_en   [NPORT],
    input  logic [XLEN-1:0] wr_word [NPORT]
);
    logic [XLEN-1:0] mem_d [NREGS];
    logic [XLEN-1:0] mem_q [NREGS];

    function automatic logic live(input logic [AW-1:0] a);
        return (a != '0) && (int'(a) < NREGS);
    endfunction

    // port order gives priority: the higher port index is applied last
    always_comb begin
        mem_d = mem_q;
        for (int p = 0; p < NPORT; p++) begin
            if (commit && wr_en[p] && live(wr_addr[p]))
                mem_d[int'(wr_addr[p])] = wr_word[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rd_word[p] = live(rd_addr[p]) ? mem_q[int'(rd_addr[p])] : '0;
    end

endmodule

// File: rtl/rfb_top.sv
// Bit-serial register file: two serial read and two serial write ports.
module rfb_top
    import rfb_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREGS  = 36,
    parameter int AW     = 6,
    parameter int RD_LAT = 2,
    parameter int WR_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic          rd_rdy,
    output logic          rd_bit_a,
    output logic          rd_bit_b,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_addr_a,
    input  logic [AW-1:0] wr_addr_b,
    input  logic          wr_en_a,
    input  logic          wr_en_b,
    output logic          wr_rdy,
    input  logic          wr_bit_a,
    input  logic          wr_bit_b
);
    logic rd_cap, rd_stream, rd_last;
    logic wr_cap, wr_stream, wr_last;

    logic [AW-1:0]   rd_addr_v [NPORT];
    logic [XLEN-1:0] rd_word_v [NPORT];
    logic            rd_bit_v  [NPORT];
    logic [AW-1:0]   wr_addr_i [NPORT];
    logic            wr_en_i   [NPORT];
    logic            wr_bit_v  [NPORT];
    logic [AW-1:0]   wr_addr_q [NPORT];
    logic            wr_en_q   [NPORT];
    logic [XLEN-1:0] wr_word_v [NPORT];

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;
    assign wr_addr_i[0] = wr_addr_a;
    assign wr_addr_i[1] = wr_addr_b;
    assign wr_en_i[0]   = wr_en_a;
    assign wr_en_i[1]   = wr_en_b;
    assign wr_bit_v[0]  = wr_bit_a;
    assign wr_bit_v[1]  = wr_bit_b;
    assign rd_bit_a     = rd_bit_v[0];
    assign rd_bit_b     = rd_bit_v[1];

    rfb_seq #(.LAT(RD_LAT), .XLEN(XLEN)) u_rd_seq (
        .clk(clk), .rst_n(rst_n), .req(rd_req),
        .capture(rd_cap), .rdy(rd_rdy), .stream(rd_stream), .last_bit(rd_last)
    );

    rfb_seq #(.LAT(WR_LAT), .XLEN(XLEN)) u_wr_seq (
        .clk(clk), .rst_n(rst_n), .req(wr_req),
        .capture(wr_cap), .rdy(wr_rdy), .stream(wr_stream), .last_bit(wr_last)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rfb_rdpath #(.XLEN(XLEN)) u_rd (
            .clk(clk), .rst_n(rst_n), .capture(rd_cap), .stream(rd_stream),
            .word(rd_word_v[p]), .bit_o(rd_bit_v[p])
        );
        rfb_wrpath #(.XLEN(XLEN), .AW(AW)) u_wr (
            .clk(clk), .rst_n(rst_n), .capture(wr_cap), .stream(wr_stream),
            .addr_i(wr_addr_i[p]), .en_i(wr_en_i[p]), .bit_i(wr_bit_v[p]),
            .addr_o(wr_addr_q[p]), .en_o(wr_en_q[p]), .word_o(wr_word_v[p])
        );
    end

    rfb_array #(.XLEN(XLEN), .NREGS(NREGS), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr_v), .rd_word(rd_word_v),
        .commit(wr_last), .wr_addr(wr_addr_q), .wr_en(wr_en_q), .wr_word(wr_word_v)
    );

endmodule

// File: rtl/rfb_checker.sv
// Protocol checker bound to rfb_top; keeps its own cycle counts per direction.
module rfb_checker #(
    parameter int XLEN   = 32,
    parameter int NREGS  = 36,
    parameter int AW     = 6,
    parameter int RD_LAT = 2,
    parameter int WR_LAT = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr_a,
    input logic [AW-1:0] rd_addr_b,
    input logic          rd_rdy,
    input logic          rd_bit_a,
    input logic          rd_bit_b,
    input logic          wr_req,
    input logic          wr_rdy
);
    int   rc_q, wc_q;
    logic zero_a_q, zero_b_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_q     <= 0;
            wc_q     <= 0;
            zero_a_q <= 1'b0;
            zero_b_q <= 1'b0;
        end else begin
            if (rc_q == 0)                 rc_q <= rd_req ? 1 : 0;
            else if (rc_q == RD_LAT + XLEN) rc_q <= 0;
            else                           rc_q <= rc_q + 1;

            if (wc_q == 0)                 wc_q <= wr_req ? 1 : 0;
            else if (wc_q == WR_LAT + XLEN) wc_q <= 0;
            else                           wc_q <= wc_q + 1;

            if (rc_q == 1) begin
                zero_a_q <= (rd_addr_a == '0) || (int'(rd_addr_a) >= NREGS);
                zero_b_q <= (rd_addr_b == '0) || (int'(rd_addr_b) >= NREGS);
            end
        end
    end

    AST_RD_RDY_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rdy == (rc_q == RD_LAT)); // R2
    AST_RD_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rdy |=> !rd_rdy); // R10
    AST_WR_RDY_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rdy == (wc_q == WR_LAT)); // R4
    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_q > RD_LAT && zero_a_q) |-> !rd_bit_a); // R7
    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_q > RD_LAT && zero_b_q) |-> !rd_bit_b); // R8

endmodule

bind rfb_top rfb_checker #(
    .XLEN(XLEN), .NREGS(NREGS), .AW(AW), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_rdy(rd_rdy),
    .rd_bit_a(rd_bit_a), .rd_bit_b(rd_bit_b),
    .wr_req(wr_req), .wr_rdy(wr_rdy)
);

// File: tb/tb_rfb_top.sv
module tb_rfb_top;
    localparam int RD_LAT = 2;
    localparam int WR_LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_req = 1'b0, wr_req = 1'b0;
    logic [5:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr_a = '0, wr_addr_b = '0;
    logic       wr_en_a = 1'b0, wr_en_b = 1'b0, wr_bit_a = 1'b0, wr_bit_b = 1'b0;
    logic       rd_rdy, rd_bit_a, rd_bit_b, wr_rdy;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk; // 50 MHz

    rfb_top #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_rdy(rd_rdy), .rd_bit_a(rd_bit_a), .rd_bit_b(rd_bit_b),
        .wr_req(wr_req), .wr_addr_a(wr_addr_a), .wr_addr_b(wr_addr_b),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_rdy(wr_rdy),
        .wr_bit_a(wr_bit_a), .wr_bit_b(wr_bit_b)
    );

    typedef struct packed {
        logic [5:0]  wa; logic [31:0] da; logic ea;
        logic [5:0]  wb; logic [31:0] db; logic eb;
        logic [5:0]  ra; logic [5:0]  rb;
        logic [31:0] xa; logic [31:0] xb;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{6'd1,  32'hA5A5_0F0F, 1'b1, 6'd2,  32'h1234_5678, 1'b1, 6'd1,  6'd2,  32'hA5A5_0F0F, 32'h1234_5678, 4'd5}, // R5
        '{6'd3,  32'hDEAD_BEEF, 1'b0, 6'd4,  32'hCAFE_F00D, 1'b1, 6'd3,  6'd4,  32'h0000_0000, 32'hCAFE_F00D, 4'd6}, // R6
        '{6'd0,  32'hFFFF_FFFF, 1'b1, 6'd31, 32'h8000_0001, 1'b1, 6'd0,  6'd31, 32'h0000_0000, 32'h8000_0001, 4'd7}, // R7
        '{6'd32, 32'h0000_0001, 1'b1, 6'd35, 32'hFFFF_FFFF, 1'b1, 6'd32, 6'd35, 32'h0000_0001, 32'hFFFF_FFFF, 4'd8}, // R8
        '{6'd5,  32'h1111_1111, 1'b1, 6'd5,  32'h2222_2222, 1'b1, 6'd5,  6'd5,  32'h2222_2222, 32'h2222_2222, 4'd9}, // R9
        '{6'd36, 32'h7777_7777, 1'b1, 6'd63, 32'h3C3C_3C3C, 1'b1, 6'd36, 6'd63, 32'h0000_0000, 32'h0000_0000, 4'd8}, // R8
        '{6'd1,  32'h0000_0000, 1'b0, 6'd2,  32'h0000_0000, 1'b0, 6'd2,  6'd1,  32'h1234_5678, 32'hA5A5_0F0F, 4'd6}, // R6
        '{6'd33, 32'h5555_AAAA, 1'b1, 6'd1,  32'h0F0F_0F0F, 1'b0, 6'd33, 6'd1,  32'h5555_AAAA, 32'hA5A5_0F0F, 4'd3}  // R3
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [5:0] aa, input logic [31:0] da, input logic ea,
                            input logic [5:0] ab, input logic [31:0] db, input logic eb);
        step(); wr_req = 1'b1;                                   // cycle 0
        step(); wr_req = 1'b0;                                   // cycle 1
        wr_addr_a = aa; wr_addr_b = ab; wr_en_a = ea; wr_en_b = eb;
        step(); wr_addr_a = 6'd9; wr_addr_b = 6'd9; wr_en_a = 1'b0; wr_en_b = 1'b0;
        for (int c = 2; c < WR_LAT; c++) begin
            @(negedge clk) check(wr_rdy == 1'b0, "R4", "wr_rdy early", 32'(wr_rdy), 32'd0);
            step();
        end
        @(negedge clk) check(wr_rdy == 1'b1, "R4", "wr_rdy at latency", 32'(wr_rdy), 32'd1);
        for (int k = 0; k < 32; k++) begin
            step(); wr_bit_a = da[k]; wr_bit_b = db[k];
            if (k == 0) @(negedge clk) check(wr_rdy == 1'b0, "R4", "wr_rdy width", 32'(wr_rdy), 32'd0);
        end
        step(); wr_bit_a = 1'b0; wr_bit_b = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] ra, input logic [5:0] rb, input bit poke,
                           output logic [31:0] ga, output logic [31:0] gb);
        step(); rd_req = 1'b1;                                   // cycle 0
        step(); rd_req = 1'b0; rd_addr_a = ra; rd_addr_b = rb;   // cycle 1
        @(negedge clk) check(rd_rdy == 1'b0, "R2", "rd_rdy early", 32'(rd_rdy), 32'd0);
        step(); rd_addr_a = 6'h3F; rd_addr_b = 6'h3F;
        for (int c = 2; c < RD_LAT; c++) step();
        @(negedge clk) check(rd_rdy == 1'b1, "R2", "rd_rdy at latency", 32'(rd_rdy), 32'd1);
        for (int k = 0; k < 32; k++) begin
            step();
            if (poke && k == 4) rd_req = 1'b1;
            if (poke && k == 5) rd_req = 1'b0;
            @(negedge clk);
            ga[k] = rd_bit_a;
            gb[k] = rd_bit_b;
            if (k == 0) check(rd_rdy == 1'b0, "R2", "rd_rdy width", 32'(rd_rdy), 32'd0);
        end
        step();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] ga, gb, ga2, gb2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(rd_rdy == 1'b0, "R1", "rd_rdy after reset", 32'(rd_rdy), 32'd0);
        check(wr_rdy == 1'b0, "R1", "wr_rdy after reset", 32'(wr_rdy), 32'd0);

        // R1: all locations clear after reset (port A and B sweep)
        for (int a = 0; a < 36; a += 2) begin
            do_read(6'(a), 6'(a + 1), 1'b0, ga, gb);
            check(ga == 32'd0, "R1", $sformatf("reg %0d after reset", a), ga, 32'd0);
            check(gb == 32'd0, "R1", $sformatf("reg %0d after reset", a + 1), gb, 32'd0);
        end

        // table walk: write both ports, then read back
        foreach (VEC[i]) begin
            do_write(VEC[i].wa, VEC[i].da, VEC[i].ea, VEC[i].wb, VEC[i].db, VEC[i].eb);
            do_read(VEC[i].ra, VEC[i].rb, 1'b0, ga, gb);
            check(ga == VEC[i].xa, $sformatf("R%0d", VEC[i].rq), $sformatf("vector %0d port A", i), ga, VEC[i].xa);
            check(gb == VEC[i].xb, $sformatf("R%0d", VEC[i].rq), $sformatf("vector %0d port B", i), gb, VEC[i].xb);
        end

        // R10: second read request during an active stream is ignored
        do_read(6'd2, 6'd31, 1'b1, ga, gb);
        check(ga == 32'h1234_5678, "R10", "read with extra request A", ga, 32'h1234_5678);
        check(gb == 32'h8000_0001, "R10", "read with extra request B", gb, 32'h8000_0001);
        for (int c = 0; c < RD_LAT + 3; c++) begin
            @(negedge clk) check(rd_rdy == 1'b0, "R10", "no ready for ignored request", 32'(rd_rdy), 32'd0);
            step();
        end

        // R11: overlapping write and read; read sees the old contents
        fork
            do_write(6'd4, 32'h0BAD_C0DE, 1'b1, 6'd6, 32'h600D_600D, 1'b1);
            do_read(6'd4, 6'd6, 1'b0, ga, gb);
        join
        check(ga == 32'hCAFE_F00D, "R11", "overlapped read old A", ga, 32'hCAFE_F00D);
        check(gb == 32'h0000_0000, "R11", "overlapped read old B", gb, 32'h0000_0000);
        do_read(6'd6, 6'd4, 1'b0, ga2, gb2);
        check(ga2 == 32'h600D_600D, "R5", "post-overlap reg 6", ga2, 32'h600D_600D);
        check(gb2 == 32'h0BAD_C0DE, "R5", "post-overlap reg 4", gb2, 32'h0BAD_C0DE);

        // R3: walking LSB/MSB patterns keep bit order
        do_write(6'd7, 32'h0000_0001, 1'b1, 6'd8, 32'h8000_0000, 1'b1);
        do_read(6'd7, 6'd8, 1'b0, ga, gb);
        check(ga == 32'h0000_0001, "R3", "LSB-only pattern", ga, 32'h0000_0001);
        check(gb == 32'h8000_0000, "R3", "MSB-only pattern", gb, 32'h8000_0000);

        finish_run();
    end

endmodule